// File: doc/BRIEF.md
# Framed Pixel Readout Serializer

This block sends the digitised contents of a line of pixels out through one serial output. A one-clock read trigger starts a readout. A fixed number of clocks later, the block sends one frame per pixel, starting at pixel 0 and ending at the last pixel, with no gaps between frames. Each frame has a low start bit, then the eight data bits least significant bit first, then a high stop bit. One bit goes out per clock of the system clock.

Pixel values come from an external conversion source through a request/valid handshake. For each pixel, the block raises a request for one clock with the pixel index. The source must return the value with a valid flag on the following clock. After the last stop bit, a one-clock done flag marks the end of the readout. A synchronous reset strobe stops a readout at any point. The first reset strobe after power-up also starts a warm-up window. Triggers that arrive before this window has passed are ignored.

Top module: `pixel_frame_tx`

## Requirements
- R1: From power-up reset (`por_n` low) onward, `sdo` is 1 whenever no frame bit is being sent, and `done` is 0.
- R2: A trigger is accepted only if it is sampled at or after the 30th rising edge following the first `soft_rst` edge. A trigger on an earlier edge, or before any `soft_rst`, leaves `sdo` at 1 and raises no `pix_req`.
- R3: If a trigger is accepted at edge k, `sdo` stays 1 through edge k+43, and the start bit of pixel 0 appears on `sdo` from edge k+44.
- R4: Each frame is ten bits: a 0 start bit, the eight data bits with bit 0 first, and a 1 stop bit.
- R5: Frames for pixels 0 through 101 follow each other with no idle bit between them, one bit per clock. The whole stream lasts 1020 clocks.
- R6: `done` is 1 for exactly one clock, starting at the edge after the last stop bit. From that same edge, `sdo` is 1.
- R7: A trigger that arrives while a readout is waiting or sending has no effect on the stream's timing or its content.
- R8: A `soft_rst` edge during a readout returns `sdo` to 1 at that edge. No further frames, requests or `done` follow.
- R9: `pix_req` is high for one clock, with `pix_idx` giving the pixel needed next. This happens during the last latency clock for pixel 0, and during the stop bit of the previous frame for every later pixel. The source answers with `pix_valid` and `pix_data` on the following clock. If `pix_valid` is low, the frame carries zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per cycle |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| soft_rst | input | 1 | Synchronous reset strobe; aborts a readout and arms the warm-up window the first time |
| rd_trig | input | 1 | One-clock readout trigger |
| pix_req | output | 1 | Request for the next pixel value |
| pix_idx | output | 7 | Index of the pixel being requested |
| pix_valid | input | 1 | Source marks `pix_data` as valid, one clock after the request |
| pix_data | input | 8 | Pixel value from the conversion source |
| sdo | output | 1 | Serial framed output, idle high |
| done | output | 1 | One-clock pulse at the end of a complete readout |

## Verification
The bench places triggers on exact edge counts around the end of the warm-up window. It checks that a trigger on edge 29 is ignored and a trigger on edge 30 is accepted, which catches a design whose warm-up count is off by one in either direction. Every readout is sampled bit by bit from the trigger edge onward. A latency that is one clock off, a gap or overlap between frames, most-significant-bit-first data, or a value fetched one pixel late all show up as a wrong bit in a specific frame. A second trigger is injected in the middle of a stream; a design that restarts on it would shift every later frame. Aborts are issued both during the latency wait and in the middle of the stream. A design that finishes the current frame, or later fires `done`, shows a low `sdo` or a `done` pulse in the silent window after the abort.

// File: rtl/pixel_frame_tx.sv
module pixel_frame_tx #(
  parameter int NUM_PIX = 102,
  parameter int DATA_W  = 8,
  parameter int LATENCY = 44,
  parameter int WARMUP  = 30
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       soft_rst,
  input  logic                       rd_trig,
  output logic                       pix_req,
  output logic [$clog2(NUM_PIX)-1:0] pix_idx,
  input  logic                       pix_valid,
  input  logic [DATA_W-1:0]          pix_data,
  output logic                       sdo,
  output logic                       done
);
  localparam int IDX_W  = $clog2(NUM_PIX);
  localparam int BIT_W  = $clog2(DATA_W + 2);
  localparam int WAIT_W = $clog2(LATENCY);
  localparam int WARM_W = $clog2(WARMUP + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);
  localparam logic [BIT_W-1:0] STOP_POS = BIT_W'(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_DAT = BIT_W'(DATA_W);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} st_t;

  st_t               state;
  logic [BIT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  pix_cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic [WARM_W-1:0] warm_cnt;
  logic              rst_seen;
  logic [DATA_W-1:0] sh;

  wire armed    = rst_seen && (warm_cnt == '0);
  wire at_stop  = (state == ST_SEND) && (bit_cnt == STOP_POS);
  wire last_pix = (pix_cnt == LAST_IDX);

  assign pix_req = ((state == ST_WAIT) && (wait_cnt == '0)) || (at_stop && !last_pix);
  assign pix_idx = (state == ST_SEND) ? pix_cnt + 1'b1 : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_seen <= 1'b0;
      warm_cnt <= '0;
    end else if (soft_rst && !rst_seen) begin
      rst_seen <= 1'b1;
      warm_cnt <= WARM_W'(WARMUP - 1);
    end else if (warm_cnt != '0) begin
      warm_cnt <= warm_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_IDLE;
      sdo      <= 1'b1;
      done     <= 1'b0;
      bit_cnt  <= '0;
      pix_cnt  <= '0;
      wait_cnt <= '0;
      sh       <= '0;
    end else begin
      done <= 1'b0;
      if (soft_rst) begin
        state <= ST_IDLE;
        sdo   <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            sdo <= 1'b1;
            if (rd_trig && armed) begin
              state    <= ST_WAIT;
              wait_cnt <= WAIT_W'(LATENCY - 1);
            end
          end
          ST_WAIT: begin
            if (wait_cnt == '0) begin
              state   <= ST_SEND;
              sdo     <= 1'b0;
              bit_cnt <= '0;
              pix_cnt <= '0;
            end else begin
              wait_cnt <= wait_cnt - 1'b1;
            end
          end
          ST_SEND: begin
            if (bit_cnt == '0) begin
              sdo     <= pix_valid & pix_data[0];
              sh      <= pix_valid ? (pix_data >> 1) : '0;
              bit_cnt <= bit_cnt + 1'b1;
            end else if (bit_cnt < LAST_DAT) begin
              sdo     <= sh[0];
              sh      <= sh >> 1;
              bit_cnt <= bit_cnt + 1'b1;
            end else if (bit_cnt == LAST_DAT) begin
              sdo     <= 1'b1;
              bit_cnt <= STOP_POS;
            end else if (last_pix) begin
              sdo   <= 1'b1;
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              sdo     <= 1'b0;
              bit_cnt <= '0;
              pix_cnt <= pix_cnt + 1'b1;
            end
          end
          default: begin
            state <= ST_IDLE;
            sdo   <= 1'b1;
          end
        endcase
      end
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_IDLE) |-> sdo);

  p_no_start_unarmed_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_IDLE && !armed) |=> (state == ST_IDLE));

  p_start_bit_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_SEND && bit_cnt == '0) |-> !sdo);

  p_stop_bit_r4: assert property (@(posedge clk) disable iff (!por_n)
    at_stop |-> sdo);

  p_back_to_back_r5: assert property (@(posedge clk) disable iff (!por_n)
    (at_stop && !last_pix && !soft_rst) |=> (!sdo && bit_cnt == '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !done);

  p_wait_steady_r7: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_WAIT && wait_cnt != '0 && !soft_rst) |=> (state == ST_WAIT && wait_cnt == $past(wait_cnt) - 1'b1));

  p_abort_r8: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (state == ST_IDLE && sdo && !done));

  p_valid_follows_req_r9: assert property (@(posedge clk) disable iff (!por_n)
    pix_req |=> pix_valid);
endmodule

// File: tb/pixel_frame_tx_test.sv
module pixel_frame_tx_test;
  localparam int NPIX = 102;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       rd_trig = 1'b0;
  logic       pix_req;
  logic [6:0] pix_idx;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic       sdo;
  logic       done;
  logic [7:0] mem [NPIX];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pixel_frame_tx uut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .rd_trig(rd_trig),
    .pix_req(pix_req), .pix_idx(pix_idx), .pix_valid(pix_valid),
    .pix_data(pix_data), .sdo(sdo), .done(done)
  );

  always @(posedge clk) begin
    pix_valid <= pix_req;
    pix_data  <= (pix_req && int'(pix_idx) < NPIX) ? mem[pix_idx] : 8'h00;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int mul, input int add);
    for (int i = 0; i < NPIX; i++) mem[i] = 8'((i * mul + add) & 255);
  endtask

  task automatic power_up();
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_rst();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic watch_quiet(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (sdo !== 1'b1 || done !== 1'b0 || pix_req !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic read_check(input int retrig_frame);
    int idle_bad = 0;
    @(negedge clk); rd_trig = 1'b1;
    @(negedge clk); rd_trig = 1'b0;
    for (int j = 0; j < 44; j++) begin
      if (sdo !== 1'b1) idle_bad++;
      @(negedge clk);
    end
    check(idle_bad == 0, "R3 latency idle bits", idle_bad, 0);
    for (int n = 0; n < NPIX; n++) begin
      logic [9:0] fr;
      for (int b = 0; b < 10; b++) begin
        fr[b] = sdo;
        if (n == retrig_frame && b == 3) rd_trig = 1'b1;
        if (n == retrig_frame && b == 4) rd_trig = 1'b0;
        @(negedge clk);
      end
      check(fr[0] === 1'b0, $sformatf("R4 start bit frame %0d", n), fr[0], 0);
      check(fr[9] === 1'b1, $sformatf("R4 stop bit frame %0d", n), fr[9], 1);
      check(fr[8:1] === mem[n], $sformatf("R5 R9 data frame %0d", n), fr[8:1], mem[n]);
    end
    check(done === 1'b1, "R6 done after last stop", done, 1);
    check(sdo === 1'b1, "R6 idle after stream", sdo, 1);
    @(negedge clk);
    check(done === 1'b0, "R6 done one clock", done, 0);
  endtask

  task automatic t_reset_state();
    power_up();
    check(sdo === 1'b1, "R1 sdo after power-up", sdo, 1);
    check(done === 1'b0, "R1 done after power-up", done, 0);
    check(pix_req === 1'b0, "R1 no request after power-up", pix_req, 0);
  endtask

  task automatic t_warmup_early();
    @(negedge clk); rd_trig = 1'b1;
    @(negedge clk); rd_trig = 1'b0;
    watch_quiet(60, "R2 trigger before any reset");
    pulse_rst();
    repeat (28) @(negedge clk);
    rd_trig = 1'b1;
    @(negedge clk); rd_trig = 1'b0;
    watch_quiet(60, "R2 trigger on edge 29");
  endtask

  task automatic t_warmup_exact();
    power_up();
    fill(37, 5);
    pulse_rst();
    repeat (28) @(negedge clk);
    read_check(-1);
  endtask

  task automatic t_pattern_b();
    fill(0, 0);
    mem[0] = 8'hFF; mem[NPIX-1] = 8'h80; mem[50] = 8'h01;
    repeat (5) @(negedge clk);
    read_check(-1);
  endtask

  task automatic t_retrigger();
    fill(91, 200);
    read_check(40);
    check(sdo === 1'b1, "R7 no restart after stream", sdo, 1);
    watch_quiet(50, "R7 quiet after retriggered stream");
  endtask

  task automatic t_abort(input int after, input string tag);
    fill(13, 77);
    @(negedge clk); rd_trig = 1'b1;
    @(negedge clk); rd_trig = 1'b0;
    repeat (after) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check(sdo === 1'b1, {tag, " sdo at abort"}, sdo, 1);
    watch_quiet(1100, {tag, " silent after abort"});
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    fill(1, 0);
    t_reset_state();
    t_warmup_early();
    t_warmup_exact();
    t_pattern_b();
    t_retrigger();
    t_abort(20, "R8 abort in wait");
    t_abort(300, "R8 abort mid stream");
    fill(3, 9);
    read_check(-1);
    report();
    $finish;
  end
endmodule